// File: doc/BRIEF.md
# Exception Entry Stacking Sequencer

This block runs the hardware part of a small processor core's exception entry. Each cycle it looks at a vector of pending exception requests, each with a priority, and keeps only those whose priority beats a mask threshold. From an idle state it picks the best eligible request. It saves an eight-word context frame below the current stack pointer through a word-write port and, in parallel, reads that exception's handler address from a vector table through a read port. When both are finished it presents the new stack pointer, the handler address and a return-code link value for one cycle. In that same cycle it marks the taken exception as moving from pending to active.

A stronger request may show up while the frame is still being written. The block then switches its target, re-reads the vector for the new exception and leaves the frame as it is. The exception it first selected is never marked active and stays pending for a later entry. A tail-chain style entry can be requested with a skip input, which suppresses the frame writes. An alignment input makes the frame start on an 8-byte boundary, and the stacked status word records whether that adjustment was made.

Top module: `exc_entry_seq`

## Requirements
- R1: A pending request is eligible only when its priority value is numerically below `mask_level`. Lower values mean higher priority. With no eligible request the block stays idle and issues no memory request.
- R2: Among eligible requests the lowest priority value wins. On a tie the lowest index wins. The exception number of index i is 16 + i.
- R3: With final stack pointer F, the frame words sit at these addresses: F+0x00 `reg_r0`, F+0x04 `reg_r1`, F+0x08 `reg_r2`, F+0x0C `reg_r3`, F+0x10 `reg_r12`, F+0x14 `reg_lr`, F+0x18 `ret_pc`, F+0x1C the status word.
- R4: There are exactly eight writes, from the highest address down in steps of 4. Each write is held on `wr_req` with stable address and data until `wr_ack`.
- R5: F equals the incoming stack pointer minus 32. When `align_en` is 1 and `sp_in` bit 2 is 1, a further 4 is subtracted and bit 9 of the stacked status word is forced to 1. Otherwise that bit is stacked as 0. `sp_in` is assumed word aligned.
- R6: The vector read address is `vtor_base` + 4 × exception number and is held until `rd_ack`. `entry_done` rises only after all frame writes and the final vector read have completed. `new_pc` then equals the data returned by that read.
- R7: `new_lr` is 0xFFFFFFF1 when `in_handler` was 1 at entry. In thread mode it is 0xFFFFFFF9 when `use_psp` is 0 and 0xFFFFFFFD when `use_psp` is 1.
- R8: `act_set` is zero except in the single `entry_done` cycle, where it is one-hot on the taken index.
- R9: A request that becomes eligible during entry with a strictly lower priority value than the current target replaces the target and triggers a new vector read. An equal priority does not replace it. The replaced exception is not marked active and is taken by the next entry if it is still pending.
- R10: With `skip_stack` at 1 when entry starts, no frame writes are made and `new_sp` equals `sp_in`.
- R11: After reset `busy`, `wr_req`, `rd_req`, `entry_done` and `act_set` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pend_vec | input | NUM_EXC | Pending request per index |
| pend_prio | input | NUM_EXC*PRIO_W | Priority per index, packed, index 0 in the low bits |
| mask_level | input | PRIO_W | Mask threshold |
| skip_stack | input | 1 | Entry without frame writes (tail-chain) |
| align_en | input | 1 | Request 8-byte frame alignment |
| in_handler | input | 1 | Core was in handler mode |
| use_psp | input | 1 | Thread mode used the process stack |
| sp_in | input | 32 | Current stack pointer |
| reg_r0 | input | 32 | Register value to stack |
| reg_r1 | input | 32 | Register value to stack |
| reg_r2 | input | 32 | Register value to stack |
| reg_r3 | input | 32 | Register value to stack |
| reg_r12 | input | 32 | Register value to stack |
| reg_lr | input | 32 | Link register value to stack |
| ret_pc | input | 32 | Address of next instruction to resume |
| xpsr_in | input | 32 | Status word to stack |
| vtor_base | input | 32 | Vector table base address |
| wr_req | output | 1 | Frame write request |
| wr_addr | output | 32 | Frame write address |
| wr_data | output | 32 | Frame write data |
| wr_ack | input | 1 | Write accepted this cycle |
| rd_req | output | 1 | Vector read request |
| rd_addr | output | 32 | Vector read address |
| rd_data | input | 32 | Vector read data, valid with rd_ack |
| rd_ack | input | 1 | Read completes this cycle |
| busy | output | 1 | Entry in progress |
| entry_done | output | 1 | One-cycle handler start |
| act_set | output | NUM_EXC | Pending-to-active move for the taken index |
| new_sp | output | 32 | Stack pointer after entry |
| new_pc | output | 32 | Handler start address |
| new_lr | output | 32 | Return-code link value |

## Verification
The hardest case to reach from the ports is a stronger request that arrives after the frame writes have begun but before the entry finishes. If it arrives at the wrong moment it would either start a new entry or miss the window. The bench keeps the memory acknowledges random, so an entry needs at least eight write cycles. It raises a new pending bit two cycles after the entry starts. It then checks the first handler start against the newcomer and a second entry against the displaced request. A variant raises a newcomer of equal priority at a lower index, which the arbiter prefers but which must not displace the target.

// File: rtl/exc_entry_pkg.sv
// Shared constants, state type and return-code helper for the exception
// entry sequencer. Assumes a 32-bit word and an eight-word context frame.
package exc_entry_pkg;

    localparam int WORD_W      = 32;
    localparam int FRAME_WORDS = 8;
    localparam int ADJ_BIT     = 9;
    localparam int WORD_BYTES  = WORD_W / 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ENTRY = 2'd1,
        ST_FIN   = 2'd2
    } entry_state_t;

    // Link return code: upper bits all ones, low nibble encodes mode and stack.
    function automatic logic [WORD_W-1:0] ret_code(input logic handler, input logic psp);
        if (handler)
            ret_code = 32'hFFFF_FFF1;
        else if (psp)
            ret_code = 32'hFFFF_FFFD;
        else
            ret_code = 32'hFFFF_FFF9;
    endfunction

endpackage

// File: rtl/exc_prio_arb.sv
// Combinational priority selector. Keeps requests whose priority value is
// strictly below the mask threshold and returns the lowest value among them,
// lowest index first on ties. Clock and reset only feed the assertion.
module exc_prio_arb #(
    parameter int NUM_EXC = 8,
    parameter int PRIO_W  = 3,
    localparam int IDX_W  = $clog2(NUM_EXC)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_EXC-1:0]        pend_vec,
    input  logic [NUM_EXC*PRIO_W-1:0] pend_prio,
    input  logic [PRIO_W-1:0]         mask_level,
    output logic                      sel_any,
    output logic [IDX_W-1:0]          sel_idx,
    output logic [PRIO_W-1:0]         sel_prio
);

    logic [PRIO_W-1:0] prio_a [NUM_EXC];

    // Unpack the flat priority bus into one entry per index.
    for (genvar g = 0; g < NUM_EXC; g++) begin : g_unpack
        assign prio_a[g] = pend_prio[g*PRIO_W +: PRIO_W];
    end

    // Linear scan: first strictly better eligible entry replaces the choice.
    always_comb begin
        logic              found;
        logic [IDX_W-1:0]  bi;
        logic [PRIO_W-1:0] bp;
        found = 1'b0;
        bi    = '0;
        bp    = '1;
        for (int i = 0; i < NUM_EXC; i++) begin
            if (pend_vec[i] && (prio_a[i] < mask_level) && (!found || prio_a[i] < bp)) begin
                found = 1'b1;
                bi    = IDX_W'(i);
                bp    = prio_a[i];
            end
        end
        sel_any  = found;
        sel_idx  = bi;
        sel_prio = bp;
    end

    AST_SEL_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        sel_any |-> (pend_vec[sel_idx] && (prio_a[sel_idx] < mask_level))); // R1

endmodule

// File: rtl/exc_frame_unit.sv
// Context frame writer. On start it captures the eight words and the final
// stack pointer, then issues one write per acknowledge from the top slot down.
// Assumes sp_in is word aligned and start only arrives while idle.
module exc_frame_unit
    import exc_entry_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              skip,
    input  logic              align_en,
    input  logic [WORD_W-1:0] sp_in,
    input  logic [WORD_W-1:0] w_r0,
    input  logic [WORD_W-1:0] w_r1,
    input  logic [WORD_W-1:0] w_r2,
    input  logic [WORD_W-1:0] w_r3,
    input  logic [WORD_W-1:0] w_r12,
    input  logic [WORD_W-1:0] w_lr,
    input  logic [WORD_W-1:0] w_pc,
    input  logic [WORD_W-1:0] w_psr,
    input  logic              wr_ack,
    output logic              wr_req,
    output logic [WORD_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic              frame_done,
    output logic [WORD_W-1:0] frame_sp
);

    localparam int CNT_W      = $clog2(FRAME_WORDS + 1);
    localparam int SLOT_W     = $clog2(FRAME_WORDS);
    localparam int FRAME_SIZE = FRAME_WORDS * WORD_BYTES;
    localparam int BYTE_SH    = $clog2(WORD_BYTES);

    logic [FRAME_WORDS-1:0][WORD_W-1:0] word_q;
    logic [CNT_W-1:0]  beat_q;
    logic [WORD_W-1:0] base_q;
    logic              align_q;
    logic              adj;
    logic [WORD_W-1:0] top_sp;
    logic [WORD_W-1:0] psr_st;
    logic [SLOT_W-1:0] slot;

    // Alignment adjust and the stacked status word with the adjust flag.
    always_comb begin
        adj            = align_en && sp_in[2];
        top_sp         = adj ? (sp_in - WORD_W'(WORD_BYTES)) : sp_in;
        psr_st         = w_psr;
        psr_st[ADJ_BIT] = adj;
    end

    // Current slot counts down from the top of the frame.
    always_comb begin
        slot       = SLOT_W'(FRAME_WORDS - 1) - beat_q[SLOT_W-1:0];
        frame_done = (beat_q == CNT_W'(FRAME_WORDS));
        wr_req     = !frame_done;
        wr_addr    = base_q + (WORD_W'(slot) << BYTE_SH);
        wr_data    = word_q[slot];
        frame_sp   = base_q;
    end

    // Capture frame on start, advance one slot per accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q  <= '0;
            beat_q  <= CNT_W'(FRAME_WORDS);
            base_q  <= '0;
            align_q <= 1'b0;
        end else if (start) begin
            word_q[0] <= w_r0;
            word_q[1] <= w_r1;
            word_q[2] <= w_r2;
            word_q[3] <= w_r3;
            word_q[4] <= w_r12;
            word_q[5] <= w_lr;
            word_q[6] <= w_pc;
            word_q[7] <= psr_st;
            base_q    <= skip ? sp_in : (top_sp - WORD_W'(FRAME_SIZE));
            align_q   <= align_en && !skip;
            beat_q    <= skip ? CNT_W'(FRAME_WORDS) : '0;
        end else if (wr_req && wr_ack) begin
            beat_q <= beat_q + 1'b1;
        end
    end

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_data))); // R4

    AST_WR_WORD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> (wr_addr[1:0] == 2'b00)); // R3

    AST_FRAME_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(frame_done) && align_q) |-> (frame_sp[2:0] == 3'b000)); // R5

endmodule

// File: rtl/exc_entry_ctrl.sv
// Entry controller. Starts an entry from idle, fetches the handler vector,
// retargets on a strictly stronger late request, and raises handler start
// once the frame and the vector are both complete. Assumes vtor_base is
// stable during an entry.
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int NUM_EXC   = 8,
    parameter int PRIO_W    = 3,
    parameter int FIRST_NUM = 16,
    localparam int IDX_W    = $clog2(NUM_EXC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               arb_any,
    input  logic [IDX_W-1:0]   arb_idx,
    input  logic [PRIO_W-1:0]  arb_prio,
    input  logic               frame_done,
    input  logic               in_handler,
    input  logic               use_psp,
    input  logic [WORD_W-1:0]  vtor_base,
    input  logic               rd_ack,
    input  logic [WORD_W-1:0]  rd_data,
    output logic               start,
    output logic               rd_req,
    output logic [WORD_W-1:0]  rd_addr,
    output logic               busy,
    output logic               entry_done,
    output logic [NUM_EXC-1:0] act_set,
    output logic [WORD_W-1:0]  new_pc,
    output logic [WORD_W-1:0]  new_lr
);

    localparam int BYTE_SH = $clog2(WORD_BYTES);

    entry_state_t      state_q;
    logic [IDX_W-1:0]  tgt_idx_q;
    logic [PRIO_W-1:0] tgt_prio_q;
    logic              vec_ok_q;
    logic [WORD_W-1:0] pc_q;
    logic              mode_q;
    logic              psp_q;
    logic              late;
    logic              finish;
    logic [WORD_W-1:0] exc_num;

    // Entry decisions derived from state and arbiter outcome.
    always_comb begin
        start   = (state_q == ST_IDLE) && arb_any;
        late    = (state_q == ST_ENTRY) && arb_any && (arb_prio < tgt_prio_q);
        finish  = (state_q == ST_ENTRY) && frame_done && vec_ok_q && !late;
        rd_req  = (state_q == ST_ENTRY) && !vec_ok_q;
        exc_num = WORD_W'(FIRST_NUM) + WORD_W'(tgt_idx_q);
        rd_addr = vtor_base + (exc_num << BYTE_SH);
    end

    // Handler start outputs, valid in the finish state only.
    always_comb begin
        busy       = (state_q != ST_IDLE);
        entry_done = (state_q == ST_FIN);
        act_set    = '0;
        for (int i = 0; i < NUM_EXC; i++) begin
            if (entry_done && (tgt_idx_q == IDX_W'(i)))
                act_set[i] = 1'b1;
        end
        new_pc = pc_q;
        new_lr = ret_code(mode_q, psp_q);
    end

    // Sequencing of target, vector fetch and entry state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            tgt_idx_q  <= '0;
            tgt_prio_q <= '0;
            vec_ok_q   <= 1'b0;
            pc_q       <= '0;
            mode_q     <= 1'b0;
            psp_q      <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q    <= ST_ENTRY;
                        tgt_idx_q  <= arb_idx;
                        tgt_prio_q <= arb_prio;
                        vec_ok_q   <= 1'b0;
                        mode_q     <= in_handler;
                        psp_q      <= use_psp && !in_handler;
                    end
                end
                ST_ENTRY: begin
                    if (late) begin
                        tgt_idx_q  <= arb_idx;
                        tgt_prio_q <= arb_prio;
                        vec_ok_q   <= 1'b0;
                    end else if (rd_req && rd_ack) begin
                        vec_ok_q <= 1'b1;
                        pc_q     <= rd_data;
                    end
                    if (finish)
                        state_q <= ST_FIN;
                end
                ST_FIN:  state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_DONE_AFTER_WORK: assert property (@(posedge clk) disable iff (!rst_n)
        entry_done |-> ($past(frame_done) && $past(vec_ok_q))); // R6

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack && !late) |=> (rd_req && $stable(rd_addr))); // R6

    AST_LATE_STRICT: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_ENTRY) && ($past(state_q) == ST_ENTRY) && (tgt_idx_q != $past(tgt_idx_q)))
            |-> (tgt_prio_q < $past(tgt_prio_q))); // R9

    AST_ACT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        entry_done |-> $onehot(act_set)); // R8

    AST_ACT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !entry_done |-> (act_set == '0)); // R8

    AST_LR_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        entry_done |-> (new_lr[WORD_W-1:4] == '1)); // R7

endmodule

// File: rtl/exc_entry_seq.sv
// Exception entry sequencer top. Joins the priority selector, the frame
// writer and the entry controller. Memory ports use a request held until a
// same-cycle acknowledge; the stack pointer input is assumed word aligned.
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter int NUM_EXC   = 8,
    parameter int PRIO_W    = 3,
    parameter int FIRST_NUM = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_EXC-1:0]        pend_vec,
    input  logic [NUM_EXC*PRIO_W-1:0] pend_prio,
    input  logic [PRIO_W-1:0]         mask_level,
    input  logic                      skip_stack,
    input  logic                      align_en,
    input  logic                      in_handler,
    input  logic                      use_psp,
    input  logic [31:0]               sp_in,
    input  logic [31:0]               reg_r0,
    input  logic [31:0]               reg_r1,
    input  logic [31:0]               reg_r2,
    input  logic [31:0]               reg_r3,
    input  logic [31:0]               reg_r12,
    input  logic [31:0]               reg_lr,
    input  logic [31:0]               ret_pc,
    input  logic [31:0]               xpsr_in,
    input  logic [31:0]               vtor_base,
    output logic                      wr_req,
    output logic [31:0]               wr_addr,
    output logic [31:0]               wr_data,
    input  logic                      wr_ack,
    output logic                      rd_req,
    output logic [31:0]               rd_addr,
    input  logic [31:0]               rd_data,
    input  logic                      rd_ack,
    output logic                      busy,
    output logic                      entry_done,
    output logic [NUM_EXC-1:0]        act_set,
    output logic [31:0]               new_sp,
    output logic [31:0]               new_pc,
    output logic [31:0]               new_lr
);

    localparam int IDX_W = $clog2(NUM_EXC);

    logic              arb_any;
    logic [IDX_W-1:0]  arb_idx;
    logic [PRIO_W-1:0] arb_prio;
    logic              start;
    logic              frame_done;

    exc_prio_arb #(
        .NUM_EXC (NUM_EXC),
        .PRIO_W  (PRIO_W)
    ) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .pend_vec   (pend_vec),
        .pend_prio  (pend_prio),
        .mask_level (mask_level),
        .sel_any    (arb_any),
        .sel_idx    (arb_idx),
        .sel_prio   (arb_prio)
    );

    exc_frame_unit u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .skip       (skip_stack),
        .align_en   (align_en),
        .sp_in      (sp_in),
        .w_r0       (reg_r0),
        .w_r1       (reg_r1),
        .w_r2       (reg_r2),
        .w_r3       (reg_r3),
        .w_r12      (reg_r12),
        .w_lr       (reg_lr),
        .w_pc       (ret_pc),
        .w_psr      (xpsr_in),
        .wr_ack     (wr_ack),
        .wr_req     (wr_req),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .frame_done (frame_done),
        .frame_sp   (new_sp)
    );

    exc_entry_ctrl #(
        .NUM_EXC   (NUM_EXC),
        .PRIO_W    (PRIO_W),
        .FIRST_NUM (FIRST_NUM)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .arb_any    (arb_any),
        .arb_idx    (arb_idx),
        .arb_prio   (arb_prio),
        .frame_done (frame_done),
        .in_handler (in_handler),
        .use_psp    (use_psp),
        .vtor_base  (vtor_base),
        .rd_ack     (rd_ack),
        .rd_data    (rd_data),
        .start      (start),
        .rd_req     (rd_req),
        .rd_addr    (rd_addr),
        .busy       (busy),
        .entry_done (entry_done),
        .act_set    (act_set),
        .new_pc     (new_pc),
        .new_lr     (new_lr)
    );

endmodule

// File: tb/exc_entry_seq_test.sv
`timescale 1ns/1ps
module exc_entry_seq_test;

    localparam int N  = 8;
    localparam int PW = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    pend_vec = '0;
    logic [N*PW-1:0] pend_prio;
    logic [PW-1:0]   mask_level = '0;
    logic            skip_stack = 1'b0, align_en = 1'b0, in_handler = 1'b0, use_psp = 1'b0;
    logic [31:0]     sp_in = 32'h2000_1000;
    logic [31:0]     reg_r0 = '0, reg_r1 = '0, reg_r2 = '0, reg_r3 = '0;
    logic [31:0]     reg_r12 = '0, reg_lr = '0, ret_pc = '0, xpsr_in = '0;
    logic [31:0]     vtor_base = 32'h0000_0400;
    logic            wr_req, rd_req, busy, entry_done;
    logic [31:0]     wr_addr, wr_data, rd_addr, new_sp, new_pc, new_lr;
    logic            wr_ack = 1'b0, rd_ack = 1'b0;
    logic [31:0]     rd_data = '0;
    logic [N-1:0]    act_set;

    logic [PW-1:0]   bprio [N];
    int              n_chk = 0, n_fail = 0;
    int              wcnt;
    logic [31:0]     wlog_a [16];
    logic [31:0]     wlog_d [16];

    always #2 clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) pend_prio[i*PW +: PW] = bprio[i];
    end

    exc_entry_seq uut (
        .clk(clk), .rst_n(rst_n), .pend_vec(pend_vec), .pend_prio(pend_prio),
        .mask_level(mask_level), .skip_stack(skip_stack), .align_en(align_en),
        .in_handler(in_handler), .use_psp(use_psp), .sp_in(sp_in),
        .reg_r0(reg_r0), .reg_r1(reg_r1), .reg_r2(reg_r2), .reg_r3(reg_r3),
        .reg_r12(reg_r12), .reg_lr(reg_lr), .ret_pc(ret_pc), .xpsr_in(xpsr_in),
        .vtor_base(vtor_base), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_ack(wr_ack), .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
        .rd_ack(rd_ack), .busy(busy), .entry_done(entry_done), .act_set(act_set),
        .new_sp(new_sp), .new_pc(new_pc), .new_lr(new_lr)
    );

    function automatic logic [31:0] vec_fn(input logic [31:0] a);
        return a ^ 32'h5A3C_0001;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    // One cycle: at the falling edge answer memory requests and log writes.
    task automatic step();
        @(negedge clk);
        wr_ack = wr_req && ($urandom % 4 != 0);
        if (wr_req && wr_ack && wcnt < 16) begin
            wlog_a[wcnt] = wr_addr;
            wlog_d[wcnt] = wr_data;
        end
        if (wr_req && wr_ack) wcnt++;
        rd_data = vec_fn(rd_addr);
        rd_ack  = rd_req && ($urandom % 3 != 0);
    endtask

    // Model winner: lowest value strictly under the mask, lowest index on ties.
    function automatic int model_best();
        int bi = -1;
        for (int i = 0; i < N; i++)
            if (pend_vec[i] && bprio[i] < mask_level && (bi < 0 || bprio[i] < bprio[bi])) bi = i;
        return bi;
    endfunction

    task automatic wait_entry(input int late_at, input int late_idx, input logic [PW-1:0] late_p, output bit got);
        int n = 0;
        got  = 1'b0;
        wcnt = 0;
        while (!got && n < 400) begin
            step();
            n++;
            if (n == late_at) begin
                bprio[late_idx]    = late_p;
                pend_vec[late_idx] = 1'b1;
            end
            if (entry_done) got = 1'b1;
        end
        if (!got) chk(1'b0, "R6 handler start missing", 32'd0, 32'd1);
    endtask

    task automatic check_entry(input int idx, input string atag);
        logic        adj  = align_en && sp_in[2] && !skip_stack;
        logic [31:0] fsp  = skip_stack ? sp_in : sp_in - (adj ? 32'd36 : 32'd32);
        logic [31:0] psr  = xpsr_in;
        logic [31:0] w [8];
        logic [31:0] lr  = in_handler ? 32'hFFFF_FFF1 : (use_psp ? 32'hFFFF_FFFD : 32'hFFFF_FFF9);
        psr[9] = adj;
        w[0] = reg_r0; w[1] = reg_r1; w[2] = reg_r2; w[3] = reg_r3;
        w[4] = reg_r12; w[5] = reg_lr; w[6] = ret_pc; w[7] = psr;
        if (skip_stack) begin
            chk(wcnt == 0, "R10 write count", wcnt, 0);
            chk(new_sp == sp_in, "R10 new_sp", new_sp, sp_in);
        end else begin
            chk(wcnt == 8, "R4 write count", wcnt, 8);
            for (int k = 0; k < 8 && k < wcnt; k++) begin
                chk(wlog_a[k] == fsp + 32'(28 - 4*k), "R4 write address order", wlog_a[k], fsp + 32'(28 - 4*k));
                chk(wlog_d[k] == w[7-k], "R3 frame word", wlog_d[k], w[7-k]);
            end
            if (wcnt > 0) chk(wlog_d[0][9] == adj, "R5 status adjust bit", 32'(wlog_d[0][9]), 32'(adj));
            chk(new_sp == fsp, "R5 new_sp", new_sp, fsp);
        end
        chk(new_pc == vec_fn(vtor_base + 32'((16 + idx) * 4)), "R6 vector", new_pc,
            vec_fn(vtor_base + 32'((16 + idx) * 4)));
        chk(new_lr == lr, "R7 link code", new_lr, lr);
        chk(act_set == N'(1 << idx), atag, 32'(act_set), 32'(1 << idx));
    endtask

    // late_mode: 0 none, 1 strictly stronger newcomer, 2 equal newcomer at lower index.
    task automatic run_case(input int late_mode);
        int  w = model_best();
        int  li = -1;
        bit  got;
        logic [PW-1:0] lp = '0;
        if (w < 0) begin
            wcnt = 0;
            repeat (6) step();
            chk(!busy && !rd_req && wcnt == 0, "R1 masked request ignored", 32'(busy), 0);
            pend_vec = '0;
            step();
            return;
        end
        if (late_mode == 1 && !skip_stack && bprio[w] > 0) begin
            for (int i = 0; i < N; i++) if (!pend_vec[i] && li < 0) li = i;
            lp = PW'($urandom % bprio[w]);
        end else if (late_mode == 2 && !skip_stack) begin
            for (int i = 0; i < w; i++) if (!pend_vec[i] && li < 0) li = i;
            lp = bprio[w];
        end
        if (li >= 0) wait_entry(2, li, lp, got);
        else         wait_entry(0, 0, '0, got);
        if (!got) return;
        if (li >= 0 && late_mode == 1) begin
            check_entry(li, "R9 late arrival takes newcomer");
            pend_vec[li] = 1'b0;
            wait_entry(0, 0, '0, got);
            if (got) check_entry(w, "R9 displaced request stays pending");
        end else if (li >= 0) begin
            check_entry(w, "R9 equal priority does not displace");
        end else begin
            check_entry(w, "R8 active set");
        end
        pend_vec = '0;
        step();
        step();
    endtask

    task automatic rand_inputs();
        reg_r0 = $urandom; reg_r1 = $urandom; reg_r2 = $urandom; reg_r3 = $urandom;
        reg_r12 = $urandom; reg_lr = $urandom; ret_pc = $urandom; xpsr_in = $urandom;
        sp_in = 32'h2000_0100 | ($urandom & 32'h0000_FFFC);
        align_en = $urandom % 2; in_handler = $urandom % 2; use_psp = $urandom % 2;
        skip_stack = ($urandom % 6 == 0);
        mask_level = ($urandom % 4 == 0) ? PW'($urandom) : '1;
        for (int i = 0; i < N; i++) bprio[i] = PW'($urandom);
        pend_vec = N'($urandom);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < N; i++) bprio[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(!busy && !wr_req && !rd_req && !entry_done && act_set == '0, "R11 reset state",
            {busy, wr_req, rd_req, entry_done, 28'(act_set)}, 32'd0);

        // R1 boundary: priority equal to mask is not taken, one below is.
        rand_inputs(); skip_stack = 0; pend_vec = '0; bprio[4] = 3'd4; mask_level = 3'd4;
        pend_vec[4] = 1'b1;
        run_case(0);
        mask_level = 3'd5; pend_vec[4] = 1'b1;
        run_case(0);

        // R2 tie on priority picks the lower index.
        rand_inputs(); skip_stack = 0; mask_level = '1; pend_vec = '0;
        bprio[2] = 3'd3; bprio[5] = 3'd3; bprio[6] = 3'd5; pend_vec[2] = 1; pend_vec[5] = 1; pend_vec[6] = 1;
        run_case(0);

        // R5 alignment corners and R7 link codes across modes.
        for (int c = 0; c < 6; c++) begin
            rand_inputs(); skip_stack = 0; mask_level = '1;
            sp_in = 32'h2000_0800 | ((c % 3 == 0) ? 32'h4 : (c % 3 == 1) ? 32'h8 : 32'hC);
            align_en = (c < 3); in_handler = (c == 1); use_psp = (c >= 2);
            pend_vec = '0; pend_vec[c] = 1'b1;
            run_case(0);
        end

        // R10 skip stacking.
        rand_inputs(); skip_stack = 1; mask_level = '1; pend_vec = 8'h10;
        run_case(0);

        // R9 strictly stronger late arrival, then equal-priority newcomer.
        rand_inputs(); skip_stack = 0; mask_level = '1; pend_vec = '0;
        bprio[5] = 3'd4; pend_vec[5] = 1'b1;
        run_case(1);
        rand_inputs(); skip_stack = 0; mask_level = '1; pend_vec = '0;
        bprio[6] = 3'd2; pend_vec[6] = 1'b1;
        run_case(2);

        // Random mix.
        for (int t = 0; t < 300; t++) begin
            rand_inputs();
            run_case($urandom % 3);
        end
        finish_run();
    end

endmodule